// File: doc/BRIEF.md
# Domain and Permission Fault Checker

This block takes the result of a finished page-table walk, or stimulus driven straight at its inputs. It decides whether a memory access may go ahead. The inputs are the access attributes: domain number, 2-bit access-permission code, section/page flag, privilege, access kind, virtual address and two permission-override control bits. The block also reads the 32-bit domain access control word, which holds one 2-bit mode for each of the 16 domains.

For each strobed request it returns a registered verdict one cycle later. The verdict has four parts: whether the access is allowed, whether the translation may be cached, whether a prefetch abort is raised, and whether a data abort is raised. When a fault is of a kind that must be recorded, the block writes an 8-bit fault status word and a 32-bit fault address. The status word packs the domain in its upper nibble and a fault code in its lower nibble. The fault address is the untranslated address. Software reads both words back on output ports.

Top module: `mmu_access_guard`

## Requirements
- R1: After reset, rsp_valid_o, allow_o, cacheable_o, pf_abort_o and data_abort_o are 0, and fsr_o and far_o are 0.
- R2: A request strobed with req_valid_i produces its verdict on the outputs one clock later with rsp_valid_o = 1. In a cycle with no strobe, the next cycle shows rsp_valid_o = 0 and both abort outputs at 0, and fsr_o and far_o keep their values.
- R3: With xlat_en_i = 0, every access is allowed, no abort is raised, cacheable_o = 0 and the fault registers are unchanged.
- R4: With walk_fault_i = 1 (and translation enabled), a translation fault is raised; it takes precedence over the domain and permission checks. Its status code is 0x5 for a section and 0x7 for a page. For a read (kind_i = 2'b01) or a write (kind_i = 2'b10), data_abort_o pulses and the fault registers are written. For a fetch (kind_i = 2'b00), pf_abort_o pulses and the fault registers are unchanged.
- R5: The domain mode is dacr_i[2*d+1:2*d] for domain d. Mode 2'b00 gives a domain fault for every access kind, including fetches. The fault is reported on data_abort_o, with status 0x9 for a section and 0xB for a page, and fault registers written.
- R6: Mode 2'b11 (manager) allows the access with no permission check and sets cacheable_o = 1.
- R7: Mode 2'b10 (reserved) allows the access with no permission check and sets cacheable_o = 0.
- R8: Mode 2'b01 (client) with ap_i != 0 works as follows. Privileged accesses always pass. For user accesses, ap_i = 1 denies all, ap_i = 2 allows reads and fetches only, and ap_i = 3 allows all. A passing client access sets cacheable_o = 1.
- R9: For a client with ap_i = 0, writes are always denied. Reads and fetches depend on {sys_s_i, sys_r_i}: 00 denies, 10 passes only when privileged, 01 passes, and 11 denies.
- R10: A failed permission check on a read or write pulses data_abort_o and writes status 0xD (section) or 0xF (page). On a fetch it pulses pf_abort_o and leaves the fault registers unchanged.
- R11: At most one abort output is high in a cycle. When an abort is high, allow_o and cacheable_o are 0.
- R12: On a recorded fault, fsr_o becomes {dom_i, status} and far_o becomes vaddr_i. This applies to domain 15 and domain 0 alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| xlat_en_i | input | 1 | Translation enable; 0 lets all accesses through |
| walk_fault_i | input | 1 | Table walk found no valid descriptor |
| dom_i | input | 4 | Domain of the matched entry |
| ap_i | input | 2 | Access-permission code |
| is_sect_i | input | 1 | 1 = section hit, 0 = page hit |
| priv_i | input | 1 | Privileged access |
| kind_i | input | 2 | 00 fetch, 01 read, 10 write (11 treated as read) |
| vaddr_i | input | 32 | Untranslated address |
| sys_s_i | input | 1 | Override bit granting privileged reads for AP 0 |
| sys_r_i | input | 1 | Override bit granting all reads for AP 0 |
| dacr_i | input | 32 | Domain access control word, 2 bits per domain |
| rsp_valid_o | output | 1 | Verdict valid |
| allow_o | output | 1 | Access allowed |
| cacheable_o | output | 1 | Translation may be cached |
| pf_abort_o | output | 1 | Prefetch abort pulse |
| data_abort_o | output | 1 | Data abort pulse |
| fsr_o | output | 8 | Fault status {domain, code} |
| far_o | output | 32 | Fault address |

## Verification
Each domain field is tested with its neighbours set to the opposite mode. A design that selects the wrong field therefore allows an access where it should fault, or faults where it should allow. Domain 0 and domain 15 are both tested.

The AP-0 override table is walked through all four {S,R} combinations, at both privilege levels and with writes. A design that lets the reserved combination through, or that lets an AP-0 write pass, gives a wrong allow_o.

Fetch faults are checked against the fault registers. A design that records translation or permission faults on a fetch, or that sends a fetch domain fault to the prefetch output, shows a changed fsr_o or the wrong abort pulse.

The cacheable flag is checked separately for the reserved and manager modes, so the two cannot be confused.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  typedef enum logic [1:0] {
    DM_NONE     = 2'b00,
    DM_CLIENT   = 2'b01,
    DM_RESERVED = 2'b10,
    DM_MANAGER  = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    FC_OK   = 2'b00,
    FC_XLAT = 2'b01,
    FC_DOM  = 2'b10,
    FC_PERM = 2'b11
  } fault_cls_e;
endpackage

// File: rtl/acc_dom_decode.sv
module acc_dom_decode
  import acc_guard_pkg::*;
#(
  parameter int DOM_W = 4,
  localparam int NUM_DOM = 1 << DOM_W,
  localparam int DACR_W = 2 * NUM_DOM
) (
  input  logic [DACR_W-1:0] dacr_i,
  input  logic [DOM_W-1:0]  dom_i,
  output dom_mode_e         mode_o
);
  logic [1:0] fields [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign fields[g] = dacr_i[2*g +: 2];
  end

  assign mode_o = dom_mode_e'(fields[dom_i]);
endmodule

// File: rtl/acc_perm_eval.sv
module acc_perm_eval
  import acc_guard_pkg::*;
(
  input  logic [1:0] ap_i,
  input  logic       priv_i,
  input  logic [1:0] kind_i,
  input  logic       sys_s_i,
  input  logic       sys_r_i,
  output logic       ok_o
);
  logic is_wr;
  assign is_wr = (kind_i == KIND_WRITE);

  always_comb begin
    ok_o = 1'b0;
    if (ap_i == 2'd0) begin
      // override bits only ever grant reads
      if (!is_wr) begin
        unique case ({sys_s_i, sys_r_i})
          2'b10:   ok_o = priv_i;
          2'b01:   ok_o = 1'b1;
          default: ok_o = 1'b0;
        endcase
      end
    end else if (priv_i) begin
      ok_o = 1'b1;
    end else begin
      unique case (ap_i)
        2'd2:    ok_o = !is_wr;
        2'd3:    ok_o = 1'b1;
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/acc_fault_code.sv
module acc_fault_code
  import acc_guard_pkg::*;
(
  input  fault_cls_e cls_i,
  input  logic       is_sect_i,
  output logic [3:0] code_o
);
  // section codes are odd-by-2 below page codes: low bits 01 vs 11
  always_comb begin
    unique case (cls_i)
      FC_XLAT: code_o = {2'b01, !is_sect_i, 1'b1};
      FC_DOM:  code_o = {2'b10, !is_sect_i, 1'b1};
      FC_PERM: code_o = {2'b11, !is_sect_i, 1'b1};
      default: code_o = 4'h0;
    endcase
  end
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import acc_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DOM_W  = 4,
  localparam int NUM_DOM = 1 << DOM_W,
  localparam int DACR_W  = 2 * NUM_DOM,
  localparam int FSR_W   = DOM_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              xlat_en_i,
  input  logic              walk_fault_i,
  input  logic [DOM_W-1:0]  dom_i,
  input  logic [1:0]        ap_i,
  input  logic              is_sect_i,
  input  logic              priv_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              sys_s_i,
  input  logic              sys_r_i,
  input  logic [DACR_W-1:0] dacr_i,
  output logic              rsp_valid_o,
  output logic              allow_o,
  output logic              cacheable_o,
  output logic              pf_abort_o,
  output logic              data_abort_o,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [ADDR_W-1:0] far_o
);
  dom_mode_e  mode;
  logic       perm_ok;
  fault_cls_e cls;
  logic [3:0] code;
  logic       allow_d, cache_d, pf_d, da_d;

  acc_dom_decode #(.DOM_W(DOM_W)) u_dom (
    .dacr_i (dacr_i),
    .dom_i  (dom_i),
    .mode_o (mode)
  );

  acc_perm_eval u_perm (
    .ap_i    (ap_i),
    .priv_i  (priv_i),
    .kind_i  (kind_i),
    .sys_s_i (sys_s_i),
    .sys_r_i (sys_r_i),
    .ok_o    (perm_ok)
  );

  acc_fault_code u_code (
    .cls_i     (cls),
    .is_sect_i (is_sect_i),
    .code_o    (code)
  );

  always_comb begin
    cls     = FC_OK;
    allow_d = 1'b0;
    cache_d = 1'b0;
    if (!xlat_en_i) begin
      allow_d = 1'b1;
    end else if (walk_fault_i) begin
      cls = FC_XLAT;
    end else begin
      unique case (mode)
        DM_NONE:     cls = FC_DOM;
        DM_CLIENT: begin
          if (perm_ok) begin
            allow_d = 1'b1;
            cache_d = 1'b1;
          end else begin
            cls = FC_PERM;
          end
        end
        DM_RESERVED: allow_d = 1'b1;
        default: begin
          allow_d = 1'b1;
          cache_d = 1'b1;
        end
      endcase
    end
  end

  // fetch faults go to prefetch abort, except domain faults which are recorded
  assign pf_d = (cls != FC_OK) && (cls != FC_DOM) && (kind_i == KIND_FETCH);
  assign da_d = (cls != FC_OK) && !pf_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      allow_o      <= 1'b0;
      cacheable_o  <= 1'b0;
      pf_abort_o   <= 1'b0;
      data_abort_o <= 1'b0;
      fsr_o        <= '0;
      far_o        <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      allow_o      <= req_valid_i && allow_d;
      cacheable_o  <= req_valid_i && cache_d;
      pf_abort_o   <= req_valid_i && pf_d;
      data_abort_o <= req_valid_i && da_d;
      if (req_valid_i && da_d) begin
        fsr_o <= {dom_i, code};
        far_o <= vaddr_i;
      end
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !pf_abort_o && !data_abort_o
                     && $stable(fsr_o) && $stable(far_o));

  p_disabled_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !xlat_en_i |=> allow_o && !pf_abort_o && !data_abort_o);

  p_abort_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pf_abort_o, data_abort_o}));

  p_abort_denies_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_abort_o || data_abort_o) |-> !allow_o && !cacheable_o);

  p_prefetch_no_record_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_abort_o |-> $stable(fsr_o) && $stable(far_o));

  p_fetch_dom_record_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && xlat_en_i && !walk_fault_i && (kind_i == KIND_FETCH)
      && (dacr_i[2*dom_i +: 2] == 2'b00) |=> data_abort_o && (far_o == $past(vaddr_i)));
endmodule

// File: tb/mmu_access_guard_tb_top.sv
module mmu_access_guard_tb_top;
  localparam int CYC = 4;

  typedef struct packed {
    logic [3:0] tag;
    logic       en;
    logic       wf;
    logic [3:0] dom;
    logic [1:0] ap;
    logic       sect;
    logic       priv;
    logic [1:0] kind;
    logic       s;
    logic       r;
    logic [1:0] mode;
    logic       allow;
    logic       cache;
    logic       pf;
    logic       da;
    logic [3:0] st;
  } vec_t;

  localparam int NV = 23;
  // tag en wf dom ap sect priv kind s r mode | allow cache pf da st
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b0,1'b0,4'd2, 2'd0,1'b1,1'b0,2'd1,1'b0,1'b0,2'b00, 1'b1,1'b0,1'b0,1'b0,4'h0},
    '{4'd4,  1'b1,1'b1,4'd5, 2'd3,1'b1,1'b1,2'd1,1'b0,1'b0,2'b11, 1'b0,1'b0,1'b0,1'b1,4'h5},
    '{4'd4,  1'b1,1'b1,4'd6, 2'd3,1'b0,1'b1,2'd2,1'b0,1'b0,2'b11, 1'b0,1'b0,1'b0,1'b1,4'h7},
    '{4'd4,  1'b1,1'b1,4'd1, 2'd3,1'b1,1'b1,2'd0,1'b0,1'b0,2'b11, 1'b0,1'b0,1'b1,1'b0,4'h0},
    '{4'd5,  1'b1,1'b0,4'd9, 2'd3,1'b1,1'b1,2'd1,1'b0,1'b0,2'b00, 1'b0,1'b0,1'b0,1'b1,4'h9},
    '{4'd5,  1'b1,1'b0,4'd10,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'b00, 1'b0,1'b0,1'b0,1'b1,4'hB},
    '{4'd6,  1'b1,1'b0,4'd4, 2'd1,1'b1,1'b0,2'd2,1'b0,1'b0,2'b11, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd7,  1'b1,1'b0,4'd7, 2'd1,1'b1,1'b0,2'd2,1'b0,1'b0,2'b10, 1'b1,1'b0,1'b0,1'b0,4'h0},
    '{4'd8,  1'b1,1'b0,4'd3, 2'd1,1'b1,1'b1,2'd2,1'b0,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd10, 1'b1,1'b0,4'd3, 2'd1,1'b0,1'b0,2'd1,1'b0,1'b0,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hF},
    '{4'd8,  1'b1,1'b0,4'd3, 2'd2,1'b0,1'b0,2'd1,1'b0,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd10, 1'b1,1'b0,4'd3, 2'd2,1'b1,1'b0,2'd2,1'b0,1'b0,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hD},
    '{4'd8,  1'b1,1'b0,4'd3, 2'd3,1'b1,1'b0,2'd2,1'b0,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd8,  1'b1,1'b0,4'd8, 2'd2,1'b1,1'b0,2'd0,1'b0,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd10, 1'b1,1'b0,4'd8, 2'd1,1'b1,1'b0,2'd0,1'b0,1'b0,2'b01, 1'b0,1'b0,1'b1,1'b0,4'h0},
    '{4'd9,  1'b1,1'b0,4'd11,2'd0,1'b1,1'b1,2'd1,1'b0,1'b0,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hD},
    '{4'd9,  1'b1,1'b0,4'd11,2'd0,1'b1,1'b1,2'd1,1'b1,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd9,  1'b1,1'b0,4'd12,2'd0,1'b0,1'b0,2'd1,1'b1,1'b0,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hF},
    '{4'd9,  1'b1,1'b0,4'd12,2'd0,1'b0,1'b0,2'd1,1'b0,1'b1,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd9,  1'b1,1'b0,4'd13,2'd0,1'b1,1'b1,2'd1,1'b1,1'b1,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hD},
    '{4'd9,  1'b1,1'b0,4'd13,2'd0,1'b0,1'b1,2'd2,1'b0,1'b1,2'b01, 1'b0,1'b0,1'b0,1'b1,4'hF},
    '{4'd12, 1'b1,1'b0,4'd15,2'd3,1'b1,1'b0,2'd1,1'b0,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,4'h0},
    '{4'd12, 1'b1,1'b0,4'd0, 2'd3,1'b0,1'b0,2'd2,1'b0,1'b0,2'b00, 1'b0,1'b0,1'b0,1'b1,4'hB}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        xlat_en_i = 1'b0;
  logic        walk_fault_i = 1'b0;
  logic [3:0]  dom_i = '0;
  logic [1:0]  ap_i = '0;
  logic        is_sect_i = 1'b0;
  logic        priv_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [31:0] vaddr_i = '0;
  logic        sys_s_i = 1'b0;
  logic        sys_r_i = 1'b0;
  logic [31:0] dacr_i = '0;
  logic        rsp_valid_o, allow_o, cacheable_o, pf_abort_o, data_abort_o;
  logic [7:0]  fsr_o;
  logic [31:0] far_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_fsr = '0;
  logic [31:0] exp_far = '0;

  always #(CYC/2) clk_i = ~clk_i;

  mmu_access_guard dut_i (
    .clk_i, .rst_ni, .req_valid_i, .xlat_en_i, .walk_fault_i, .dom_i, .ap_i,
    .is_sect_i, .priv_i, .kind_i, .vaddr_i, .sys_s_i, .sys_r_i, .dacr_i,
    .rsp_valid_o, .allow_o, .cacheable_o, .pf_abort_o, .data_abort_o, .fsr_o, .far_o
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // neighbouring domains get the inverted mode so a wrong field select shows
  function automatic logic [31:0] mk_dacr(input logic [3:0] d, input logic [1:0] m);
    logic [31:0] w;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = ~m;
    w[2*d +: 2] = m;
    return w;
  endfunction

  task automatic drive(input int i);
    vec_t v = VECS[i];
    req_valid_i  = 1'b1;
    xlat_en_i    = v.en;
    walk_fault_i = v.wf;
    dom_i        = v.dom;
    ap_i         = v.ap;
    is_sect_i    = v.sect;
    priv_i       = v.priv;
    kind_i       = v.kind;
    sys_s_i      = v.s;
    sys_r_i      = v.r;
    dacr_i       = mk_dacr(v.dom, v.mode);
    vaddr_i      = 32'h1000_0000 + 32'(i) * 32'h0001_1111;
  endtask

  task automatic check_vec(input int i);
    vec_t v = VECS[i];
    string t = tag_name(v.tag);
    logic [31:0] va = 32'h1000_0000 + 32'(i) * 32'h0001_1111;
    if (v.da) begin
      exp_fsr = {v.dom, v.st};
      exp_far = va;
    end
    chk("R2", $sformatf("vec %0d rsp_valid", i), 32'(rsp_valid_o), 32'd1);
    chk(t, $sformatf("vec %0d allow", i), 32'(allow_o), 32'(v.allow));
    chk(t, $sformatf("vec %0d cacheable", i), 32'(cacheable_o), 32'(v.cache));
    chk(t, $sformatf("vec %0d pf_abort", i), 32'(pf_abort_o), 32'(v.pf));
    chk(t, $sformatf("vec %0d data_abort", i), 32'(data_abort_o), 32'(v.da));
    chk("R12", $sformatf("vec %0d fsr", i), 32'(fsr_o), 32'(exp_fsr));
    chk("R12", $sformatf("vec %0d far", i), far_o, exp_far);
    chk("R11", $sformatf("vec %0d abort exclusive", i),
        32'(pf_abort_o & data_abort_o), 32'd0);
  endtask

  initial begin
    #(CYC * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R1", "allow", 32'(allow_o), 32'd0);
    chk("R1", "aborts", 32'({pf_abort_o, data_abort_o, cacheable_o}), 32'd0);
    chk("R1", "fsr", 32'(fsr_o), 32'd0);
    chk("R1", "far", far_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    drive(0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      check_vec(i);
      if (i + 1 < NV) drive(i + 1);
      else req_valid_i = 1'b0;
    end

    // R2: a faulting pattern with no strobe must leave everything quiet
    xlat_en_i = 1'b1; walk_fault_i = 1'b1; kind_i = 2'd1; dom_i = 4'd7;
    vaddr_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    chk("R2", "idle rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R2", "idle aborts", 32'({pf_abort_o, data_abort_o}), 32'd0);
    chk("R2", "idle fsr", 32'(fsr_o), 32'(exp_fsr));
    chk("R2", "idle far", far_o, exp_far);

    // R3: disabled translation leaves recorded fault intact
    req_valid_i = 1'b1; xlat_en_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R3", "off allow", 32'(allow_o), 32'd1);
    chk("R3", "off cacheable", 32'(cacheable_o), 32'd0);
    chk("R3", "off fsr", 32'(fsr_o), 32'(exp_fsr));

    // R1: reset mid-run clears fault registers
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "re-reset fsr", 32'(fsr_o), 32'd0);
    chk("R1", "re-reset far", far_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule